// File: doc/BRIEF.md
# Serial Transmit Queue with Sticky Error Flags

This block sits between a register-write port and a serial shift engine. Software pushes 32-bit words into a 16-entry queue. Each time the shifter starts a new frame, it raises a load request. The block then pops the oldest word and presents it on `tx_data` until the next load.

Two misuse conditions are caught. The first is a write into a full queue, which is dropped without disturbing the stored words. The second is a load from an empty queue, which re-sends the word popped most recently. Each condition is latched in a sticky flag that software clears by writing 1. A per-flag enable routes the flag onto a single interrupt line.

Errors are only detected while transmit is enabled. Dropping the enable empties the queue but keeps the flags.

Top module: `sertx_queue`

## Requirements
- R1: The queue holds 16 words of 32 bits and returns them in write order. `full` and `empty` are registered and change in the cycle after the push or pop that alters the fill level.
- R2: A write while `tx_en`=1 and `full`=1 is discarded. The stored words and `full` are unchanged, and `ovf_flag` is 1 from the next cycle.
- R3: A load request while `tx_en`=1 and `empty`=1 sets `udf_flag` from the next cycle. `tx_data` keeps the word popped last.
- R4: `tx_data` shows the popped word from the cycle after a successful load. It is 0 after reset, so an underflow straight after reset repeats 0.
- R5: A cycle with `st_wr`=1 clears each flag whose `st_wdata` bit is 1. Bit 1 selects `ovf_flag` and bit 0 selects `udf_flag`. A 0 bit has no effect. If a flag's set event and its clear fall in the same cycle, the flag ends up set.
- R6: Flags are only set while `tx_en`=1. Clearing through `st_wr` works whatever the value of `tx_en`.
- R7: While `tx_en`=0 the queue is held empty. Writes and load requests are ignored, `tx_data` is held, and both flags keep their values.
- R8: `irq` equals (`udf_flag` AND `irq_en[0]`) OR (`ovf_flag` AND `irq_en[1]`), combinationally.
- R9: A write and a load in the same cycle, with the queue neither full nor empty, both succeed and leave `full` and `empty` unchanged.
- R10: After reset the queue is empty, `full` is 0, both flags are 0, `irq` is 0 and `tx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; 0 flushes the queue |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | 32 | Word to enqueue |
| ld_req | input | 1 | Shifter frame-load request |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 2 | Clear mask: bit 1 overflow, bit 0 underflow |
| irq_en | input | 2 | Interrupt enables: bit 1 overflow, bit 0 underflow |
| tx_data | output | 32 | Word handed to the shifter |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Gated interrupt |

## Verification
A corrupted pointer or count shows up at the ports as out-of-order or missing words on `tx_data`. It also shows as a wrong `full` or `empty` one cycle after the push or pop responsible.

The overflow case is key: only the later draining of all 16 words reveals whether the dropped write reached storage. The bench therefore pops every entry after the overflow.

A flag that sets while disabled, or that fails to clear, is seen on the flag output one cycle later. It reaches `irq` in that same cycle if the matching enable bit is on.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int FLAG_UDF = 0;
  localparam int FLAG_OVF = 1;
  localparam int NFLAG    = 2;

  // next fill level from a current level and qualified strobes
  function automatic int lvl_next(int lvl, logic push, logic pop);
    return lvl + int'(push) - int'(pop);
  endfunction

  // circular pointer advance
  function automatic int ptr_adv(int p, int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // interrupt merge of flags and enables
  function automatic logic irq_merge(logic [NFLAG-1:0] flg, logic [NFLAG-1:0] en);
    return |(flg & en);
  endfunction
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] lvl, lvl_n;

  always_comb begin
    lvl_n = flush ? '0 : CW'(sertx_pkg::lvl_next(int'(lvl), push, pop));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      lvl   <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (push) wp <= AW'(sertx_pkg::ptr_adv(int'(wp), DEPTH));
      if (pop)  rp <= AW'(sertx_pkg::ptr_adv(int'(rp), DEPTH));
      lvl   <= lvl_n;
      full  <= (lvl_n == CW'(DEPTH));
      empty <= (lvl_n == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
endmodule

// File: rtl/sertx_sticky.sv
module sertx_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag[i] <= 1'b0;
      else        flag[i] <= set[i] | (flag[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/sertx_queue.sv
module sertx_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tx_en,
  input  logic                         wr_valid,
  input  logic [DW-1:0]                wr_data,
  input  logic                         ld_req,
  input  logic                         st_wr,
  input  logic [sertx_pkg::NFLAG-1:0]  st_wdata,
  input  logic [sertx_pkg::NFLAG-1:0]  irq_en,
  output logic [DW-1:0]                tx_data,
  output logic                         full,
  output logic                         empty,
  output logic                         ovf_flag,
  output logic                         udf_flag,
  output logic                         irq
);
  import sertx_pkg::*;

  // named internal events
  logic          flush, push_ok, pop_ok, ovf_evt, udf_evt;
  logic [DW-1:0] head;
  logic [NFLAG-1:0] set_vec, clr_vec, flags;

  assign flush   = ~tx_en;
  assign push_ok = tx_en & wr_valid & ~full;
  assign pop_ok  = tx_en & ld_req & ~empty;
  assign ovf_evt = tx_en & wr_valid & full;
  assign udf_evt = tx_en & ld_req & empty;

  sertx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push_ok),
    .pop   (pop_ok),
    .wdata (wr_data),
    .rdata (head),
    .full  (full),
    .empty (empty)
  );

  // last-sent word: refreshed on a pop, held on underflow
  always_ff @(posedge clk) begin
    if (!rst_n)      tx_data <= '0;
    else if (pop_ok) tx_data <= head;
  end

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_OVF] = ovf_evt;
    set_vec[FLAG_UDF] = udf_evt;
    clr_vec           = st_wr ? st_wdata : '0;
  end

  sertx_sticky #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set_vec),
    .clr   (clr_vec),
    .flag  (flags)
  );

  assign ovf_flag = flags[FLAG_OVF];
  assign udf_flag = flags[FLAG_UDF];
  assign irq      = irq_merge(flags, irq_en);
endmodule

// File: rtl/sertx_queue_chk.sv
module sertx_queue_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          wr_valid,
  input logic          ld_req,
  input logic          st_wr,
  input logic [1:0]    st_wdata,
  input logic [DW-1:0] tx_data,
  input logic          full,
  input logic          empty,
  input logic          ovf_flag,
  input logic          udf_flag,
  input logic          irq
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R1
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n) (tx_en && wr_valid && full) |=> ovf_flag); // R2
  AST_OVF_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n) (tx_en && wr_valid && full && !ld_req) |=> full); // R2
  AST_UDF_REPEATS: assert property (@(posedge clk) disable iff (!rst_n) (tx_en && ld_req && empty) |=> (udf_flag && $stable(tx_data))); // R3
  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (st_wr && st_wdata[1] && !(tx_en && wr_valid && full)) |=> !ovf_flag); // R5
  AST_DIS_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n) (!tx_en && !ovf_flag) |=> !ovf_flag); // R6
  AST_DIS_NO_UDF: assert property (@(posedge clk) disable iff (!rst_n) (!tx_en && !udf_flag) |=> !udf_flag); // R6
  AST_DIS_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |=> empty); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!ovf_flag && !udf_flag) |-> !irq); // R8
  AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (tx_en && wr_valid && ld_req && !full && !empty) |=> ($stable(full) && $stable(empty))); // R9
endmodule

bind sertx_queue sertx_queue_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .wr_valid (wr_valid),
  .ld_req   (ld_req),
  .st_wr    (st_wr),
  .st_wdata (st_wdata),
  .tx_data  (tx_data),
  .full     (full),
  .empty    (empty),
  .ovf_flag (ovf_flag),
  .udf_flag (udf_flag),
  .irq      (irq)
);

// File: tb/tb_sertx_queue.sv
module tb_sertx_queue;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0, wr_valid = 1'b0, ld_req = 1'b0, st_wr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  st_wdata = '0, irq_en = '0;
  logic [31:0] tx_data;
  logic        full, empty, ovf_flag, udf_flag, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  sertx_queue dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .ld_req(ld_req), .st_wr(st_wr), .st_wdata(st_wdata),
    .irq_en(irq_en), .tx_data(tx_data), .full(full), .empty(empty),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag), .irq(irq)
  );

  // vector table: tx_en=1, queue empty, flags clear at its start
  typedef struct packed {
    bit       ld;
    bit       sw;
    bit [1:0] swd;
    bit [1:0] ie;
    bit       e_udf;
    bit       e_ovf;
    bit       e_irq;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 2'b00, 2'b01, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 2'b00, 2'b10, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 2'b10, 2'b01, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 2'b00, 2'b01, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 2'b01, 2'b01, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one cycle of inputs, then wait to the following falling edge
  task automatic step(logic en, logic wv, logic [31:0] wd, logic ld,
                      logic sw, logic [1:0] swd, logic [1:0] ie);
    tx_en = en; wr_valid = wv; wr_data = wd; ld_req = ld;
    st_wr = sw; st_wdata = swd; irq_en = ie;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; ld_req = 1'b0; st_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tx_en = 1'b0; wr_valid = 1'b0; ld_req = 1'b0;
    st_wr = 1'b0; st_wdata = '0; irq_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10", "empty", 32'(empty), 32'd1);
    chk("R10", "full", 32'(full), 32'd0);
    chk("R10", "ovf", 32'(ovf_flag), 32'd0);
    chk("R10", "udf", 32'(udf_flag), 32'd0);
    chk("R10", "irq", 32'(irq), 32'd0);
    chk("R10", "tx_data", tx_data, 32'd0);

    // table: R3 R5 R8 sticky flag and interrupt gating
    step(1'b1, 1'b0, '0, 1'b0, 1'b0, 2'b00, 2'b00);
    foreach (VEC[i]) begin
      step(1'b1, 1'b0, '0, VEC[i].ld, VEC[i].sw, VEC[i].swd, VEC[i].ie);
      chk("R5", $sformatf("vec%0d udf", i), 32'(udf_flag), 32'(VEC[i].e_udf));
      chk("R5", $sformatf("vec%0d ovf", i), 32'(ovf_flag), 32'(VEC[i].e_ovf));
      chk("R8", $sformatf("vec%0d irq", i), 32'(irq), 32'(VEC[i].e_irq));
    end

    // R4 underflow straight after reset repeats 0
    do_reset();
    step(1'b1, 1'b0, '0, 1'b1, 1'b0, 2'b00, 2'b00);
    chk("R4", "tx_data after reset underflow", tx_data, 32'd0);
    chk("R3", "udf after reset underflow", 32'(udf_flag), 32'd1);
    step(1'b1, 1'b0, '0, 1'b0, 1'b1, 2'b01, 2'b00);

    // R1 fill to 16
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b1, 32'hA000_0000 + 32'(i), 1'b0, 1'b0, 2'b00, 2'b00);
      if (i == 14) chk("R1", "full at 15", 32'(full), 32'd0);
    end
    chk("R1", "full at 16", 32'(full), 32'd1);
    // R2 overflow write dropped
    step(1'b1, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, 2'b00, 2'b10);
    chk("R2", "ovf set", 32'(ovf_flag), 32'd1);
    chk("R2", "full kept", 32'(full), 32'd1);
    chk("R8", "irq from ovf", 32'(irq), 32'd1);
    step(1'b1, 1'b0, '0, 1'b0, 1'b1, 2'b10, 2'b00);
    chk("R5", "ovf cleared", 32'(ovf_flag), 32'd0);
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0, '0, 1'b1, 1'b0, 2'b00, 2'b00);
      chk("R2", $sformatf("drain word %0d", i), tx_data, 32'hA000_0000 + 32'(i));
    end
    chk("R1", "empty after drain", 32'(empty), 32'd1);
    chk("R3", "no udf yet", 32'(udf_flag), 32'd0);
    step(1'b1, 1'b0, '0, 1'b1, 1'b0, 2'b00, 2'b00);
    chk("R3", "udf set", 32'(udf_flag), 32'd1);
    chk("R3", "repeat last", tx_data, 32'hA000_000F);
    step(1'b1, 1'b0, '0, 1'b0, 1'b1, 2'b01, 2'b00);

    // R9 simultaneous push and pop
    step(1'b1, 1'b1, 32'h11, 1'b0, 1'b0, 2'b00, 2'b00);
    step(1'b1, 1'b1, 32'h22, 1'b1, 1'b0, 2'b00, 2'b00);
    chk("R9", "popped first", tx_data, 32'h11);
    chk("R9", "not empty", 32'(empty), 32'd0);
    step(1'b1, 1'b0, '0, 1'b1, 1'b0, 2'b00, 2'b00);
    chk("R9", "popped second", tx_data, 32'h22);
    chk("R9", "empty after", 32'(empty), 32'd1);

    // R6 R7 disabled behaviour
    step(1'b0, 1'b0, '0, 1'b1, 1'b0, 2'b00, 2'b01);
    chk("R6", "udf not set while disabled", 32'(udf_flag), 32'd0);
    chk("R7", "tx_data held", tx_data, 32'h22);
    step(1'b0, 1'b1, 32'h33, 1'b0, 1'b0, 2'b00, 2'b00);
    chk("R7", "write dropped, empty", 32'(empty), 32'd1);
    step(1'b1, 1'b0, '0, 1'b1, 1'b0, 2'b00, 2'b00);
    chk("R7", "no stored word", tx_data, 32'h22);
    chk("R3", "udf after re-enable", 32'(udf_flag), 32'd1);
    step(1'b1, 1'b1, 32'h44, 1'b0, 1'b0, 2'b00, 2'b00);
    step(1'b1, 1'b1, 32'h55, 1'b0, 1'b0, 2'b00, 2'b00);
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, 2'b00, 2'b00);
    chk("R7", "flushed", 32'(empty), 32'd1);
    chk("R7", "flag kept over flush", 32'(udf_flag), 32'd1);
    step(1'b0, 1'b0, '0, 1'b0, 1'b1, 2'b01, 2'b00);
    chk("R6", "clear while disabled", 32'(udf_flag), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule